// File: doc/BRIEF.md
# Latchable Parity Bus Transceiver

This block joins two 9-bit buses, A and B. Each carries eight data bits and one parity bit. Data can flow from A to B or from B to A, and two active-low drive enables choose the direction. Each side has a transparent latch with its own enable. While a latch enable is HIGH, that side's word passes straight through. While it is LOW, the side presents the word it stored last. Each bus is modelled as separate input, output and output-valid ports, not as tri-state pins.

A mode input selects how the outgoing parity bit is formed. In generate mode the block computes parity over the eight source data bits and drives that result. In feed-through mode it forwards the source parity bit unchanged. A second input selects even or odd parity.

Parity checking runs on both sides at all times, in either mode. On the side being driven, the latch can be transparent. In that case the word the block drives is what that latch sees, so the far side's error flag checks the driven word as well. When both drive enables are LOW, A-to-B wins and a conflict flag rises.

The latches are clocked registers that load on each rising clock edge while their enable is HIGH. The data path picks either the live bus word or the stored word, so transparency costs no cycle.

Top module: `parity_xcvr`

## Requirements
- R1: With `drv_ab_n` LOW, the block drives B: `b_oe`=1 and `b_out` equals the A-side word, which is the live `a_in` when `lat_a_en`=1 and the stored A word otherwise.
- R2: With `drv_ab_n` HIGH and `drv_ba_n` LOW, the block drives A: `a_oe`=1, `b_oe`=0, and `a_out` equals the B-side word (live `b_in` when `lat_b_en`=1, stored otherwise).
- R3: With both drive enables HIGH, `a_oe`=`b_oe`=0. Any output whose valid bit is 0 (`a_out`, `a_par_out`, `b_out`, `b_par_out`) reads all zero.
- R4: With both drive enables LOW, A-to-B is chosen and `cfg_conflict`=1. In every other case `cfg_conflict`=0.
- R5: In generate mode (`pass_mode`=0), the driven parity bit is the XOR of the eight driven data bits XOR `odd_sel`. So `odd_sel`=0 gives even parity over all nine bits, and `odd_sel`=1 gives odd parity.
- R6: In feed-through mode (`pass_mode`=1), the driven parity bit equals the source-side parity bit, taken live or stored under the same rule as the data.
- R7: On each side, the error flag (`err_a_n`, `err_b_n`) is LOW exactly when the parity computed from that side's latched-or-live data under `odd_sel` differs from that side's parity bit. This holds in both modes.
- R8: While a latch enable is HIGH, that side's word is the current bus word, with no cycle of delay. The bus word is the driven word when that side is driven, and the input word otherwise.
- R9: While a latch enable is LOW, that side's word is the bus word sampled at the last rising clock edge at which the enable was HIGH. Reset clears both stored words, data and parity, to zero.
- R10: When the driven side's latch is transparent, that side is checked against the word being driven. In generate mode its error flag therefore stays HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the latch storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 8 | Data arriving on bus A |
| a_par_in | input | 1 | Parity arriving on bus A |
| b_in | input | 8 | Data arriving on bus B |
| b_par_in | input | 1 | Parity arriving on bus B |
| drv_ab_n | input | 1 | Active-low enable to drive bus B from A |
| drv_ba_n | input | 1 | Active-low enable to drive bus A from B |
| pass_mode | input | 1 | 0 = generate parity, 1 = feed parity through |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| lat_a_en | input | 1 | A latch transparent when 1, holding when 0 |
| lat_b_en | input | 1 | B latch transparent when 1, holding when 0 |
| a_out | output | 8 | Data driven onto bus A |
| a_par_out | output | 1 | Parity driven onto bus A |
| a_oe | output | 1 | Bus A is being driven |
| b_out | output | 8 | Data driven onto bus B |
| b_par_out | output | 1 | Parity driven onto bus B |
| b_oe | output | 1 | Bus B is being driven |
| err_a_n | output | 1 | Active-low parity error on side A |
| err_b_n | output | 1 | Active-low parity error on side B |
| cfg_conflict | output | 1 | Both drive enables were LOW |

## Verification
The bench walks all 64 combinations of the drive enables, mode, parity sense and both latch enables, several times over with random data and random parity bits. These sweeps check the following corner cases:
- A latch that opens, closes and then sees new input must keep presenting its old word. A design that lets a closed latch follow its input, or loads one cycle late, gives the wrong output data and wrong error flags.
- When both drive enables are LOW, A-to-B must win. A design with the wrong priority, or with no conflict flag, drives the wrong bus.
- A design that drops the feedback through the destination latch reports the destination's stale or input parity instead of the driven parity.
- A design that swaps the even and odd senses, or stops checking in feed-through mode, flips the error flags.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;
    parameter int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par;
    } bus_word_t;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_AB   = 2'd1,
        DIR_BA   = 2'd2
    } dir_e;

    function automatic logic par_of(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction
endpackage

// File: rtl/parity_xcvr_dir.sv
module parity_xcvr_dir
    import parity_xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drv_ab_n,
    input  logic drv_ba_n,
    output dir_e dir,
    output logic conflict
);
    always_comb begin
        conflict = !drv_ab_n && !drv_ba_n;
        if (!drv_ab_n)      dir = DIR_AB;
        else if (!drv_ba_n) dir = DIR_BA;
        else                dir = DIR_NONE;
    end

    // R3: idle enables leave no direction selected
    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_ab_n && drv_ba_n) |-> (dir == DIR_NONE));
    // R4: a conflict always resolves toward A-to-B
    assert_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (dir == DIR_AB));
endmodule

// File: rtl/parity_xcvr_latch.sv
module parity_xcvr_latch
    import parity_xcvr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  bus_word_t word_in,
    output bus_word_t held
);
    typedef struct packed {
        bus_word_t word;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) st_d.word = word_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held = st_q.word;

    // R9: a closed latch keeps its contents
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held));
    // R8: an open latch captures the presented word
    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (held == $past(word_in)));
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
    import parity_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_in,
    input  logic              a_par_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              b_par_in,
    input  logic              drv_ab_n,
    input  logic              drv_ba_n,
    input  logic              pass_mode,
    input  logic              odd_sel,
    input  logic              lat_a_en,
    input  logic              lat_b_en,
    output logic [DATA_W-1:0] a_out,
    output logic              a_par_out,
    output logic              a_oe,
    output logic [DATA_W-1:0] b_out,
    output logic              b_par_out,
    output logic              b_oe,
    output logic              err_a_n,
    output logic              err_b_n,
    output logic              cfg_conflict
);
    typedef struct packed {
        bus_word_t a_drv;
        logic      a_oe;
        bus_word_t b_drv;
        logic      b_oe;
        logic      err_a_n;
        logic      err_b_n;
    } xcvr_out_t;

    dir_e      dir;
    logic      conflict;
    bus_word_t a_bus_d, b_bus_d;
    bus_word_t a_held_q, b_held_q;
    xcvr_out_t out_d;

    parity_xcvr_dir u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .drv_ab_n (drv_ab_n),
        .drv_ba_n (drv_ba_n),
        .dir      (dir),
        .conflict (conflict)
    );

    always_comb begin
        bus_word_t a_src, b_src, to_a, to_b, a_view, b_view;
        a_src = lat_a_en ? {a_in, a_par_in} : a_held_q;
        b_src = lat_b_en ? {b_in, b_par_in} : b_held_q;

        to_b.data = a_src.data;
        to_b.par  = pass_mode ? a_src.par : par_of(a_src.data, odd_sel);
        to_a.data = b_src.data;
        to_a.par  = pass_mode ? b_src.par : par_of(b_src.data, odd_sel);

        a_bus_d = (dir == DIR_BA) ? to_a : {a_in, a_par_in};
        b_bus_d = (dir == DIR_AB) ? to_b : {b_in, b_par_in};

        a_view = lat_a_en ? a_bus_d : a_held_q;
        b_view = lat_b_en ? b_bus_d : b_held_q;

        out_d.a_oe    = (dir == DIR_BA);
        out_d.b_oe    = (dir == DIR_AB);
        out_d.a_drv   = out_d.a_oe ? to_a : '0;
        out_d.b_drv   = out_d.b_oe ? to_b : '0;
        out_d.err_a_n = (par_of(a_view.data, odd_sel) == a_view.par);
        out_d.err_b_n = (par_of(b_view.data, odd_sel) == b_view.par);
    end

    parity_xcvr_latch u_lat_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (lat_a_en),
        .word_in (a_bus_d),
        .held    (a_held_q)
    );

    parity_xcvr_latch u_lat_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (lat_b_en),
        .word_in (b_bus_d),
        .held    (b_held_q)
    );

    assign a_out        = out_d.a_drv.data;
    assign a_par_out    = out_d.a_drv.par;
    assign a_oe         = out_d.a_oe;
    assign b_out        = out_d.b_drv.data;
    assign b_par_out    = out_d.b_drv.par;
    assign b_oe         = out_d.b_oe;
    assign err_a_n      = out_d.err_a_n;
    assign err_b_n      = out_d.err_b_n;
    assign cfg_conflict = conflict;

    // R4: never drive both buses
    assert_one_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));
    // R4: a conflict resolves to driving B
    assert_conflict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_conflict |-> (b_oe && !a_oe));
    // R5: generated parity on B matches the driven data
    assert_gen_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !pass_mode) |-> (((^b_out) ^ odd_sel) == b_par_out));
    // R5: generated parity on A matches the driven data
    assert_gen_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && !pass_mode) |-> (((^a_out) ^ odd_sel) == a_par_out));
    // R6: live feed-through forwards the source parity
    assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && pass_mode && lat_a_en) |-> (b_par_out == a_par_in));
    // R10: generated parity fed back through an open latch checks clean
    assert_fb_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && lat_b_en && !pass_mode) |-> err_b_n);
    assert_fb_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && lat_a_en && !pass_mode) |-> err_a_n);
    // R3: an undriven side outputs zero
    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !b_oe |-> (b_out == '0 && !b_par_out));
endmodule

// File: tb/parity_xcvr_tb.sv
module parity_xcvr_tb;
    localparam int W = 8;

    typedef struct packed {
        logic [W-1:0] a_out;
        logic         a_par;
        logic         a_oe;
        logic [W-1:0] b_out;
        logic         b_par;
        logic         b_oe;
        logic         err_a_n;
        logic         err_b_n;
        logic         conflict;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic [W-1:0] a_in = 0, b_in = 0;
    logic a_par_in = 0, b_par_in = 0;
    logic drv_ab_n = 1, drv_ba_n = 1, pass_mode = 0, odd_sel = 0;
    logic lat_a_en = 0, lat_b_en = 0;
    logic [W-1:0] a_out, b_out;
    logic a_par_out, a_oe, b_par_out, b_oe, err_a_n, err_b_n, cfg_conflict;

    int vectors = 0, fails = 0;
    bit done = 0;
    exp_t q[$];
    logic [W:0] ma = 0, mb = 0;  // model storage {data, par}

    always #10 clk = ~clk;

    parity_xcvr u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_par_in(a_par_in), .b_in(b_in), .b_par_in(b_par_in),
        .drv_ab_n(drv_ab_n), .drv_ba_n(drv_ba_n), .pass_mode(pass_mode),
        .odd_sel(odd_sel), .lat_a_en(lat_a_en), .lat_b_en(lat_b_en),
        .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
        .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
        .err_a_n(err_a_n), .err_b_n(err_b_n), .cfg_conflict(cfg_conflict)
    );

    function automatic logic gpar(input logic [W-1:0] d, input logic odd);
        logic p = odd;
        for (int i = 0; i < W; i++) p = p ^ d[i];
        return p;
    endfunction

    task automatic apply(input logic [5:0] ctl, input logic [W-1:0] av, input logic ap,
                         input logic [W-1:0] bv, input logic bp);
        exp_t e;
        logic [W:0] asrc, bsrc, toa, tob, abus, bbus, aview, bview;
        logic ab, ba;
        @(negedge clk);
        {drv_ab_n, drv_ba_n, pass_mode, odd_sel, lat_a_en, lat_b_en} = ctl;
        a_in = av; a_par_in = ap; b_in = bv; b_par_in = bp;
        ab = !drv_ab_n;                  // R4 priority
        ba = drv_ab_n && !drv_ba_n;
        asrc = lat_a_en ? {av, ap} : ma; // R8 / R9
        bsrc = lat_b_en ? {bv, bp} : mb;
        tob = {asrc[W:1], pass_mode ? asrc[0] : gpar(asrc[W:1], odd_sel)}; // R5 / R6
        toa = {bsrc[W:1], pass_mode ? bsrc[0] : gpar(bsrc[W:1], odd_sel)};
        abus = ba ? toa : {av, ap};
        bbus = ab ? tob : {bv, bp};
        aview = lat_a_en ? abus : ma;    // R10 feedback
        bview = lat_b_en ? bbus : mb;
        e.a_oe = ba; e.b_oe = ab;
        {e.a_out, e.a_par} = ba ? toa : '0;  // R3 zero when idle
        {e.b_out, e.b_par} = ab ? tob : '0;
        e.err_a_n = (gpar(aview[W:1], odd_sel) == aview[0]); // R7
        e.err_b_n = (gpar(bview[W:1], odd_sel) == bview[0]);
        e.conflict = !drv_ab_n && !drv_ba_n;
        q.push_back(e);
        if (lat_a_en) ma = abus;
        if (lat_b_en) mb = bbus;
    endtask

    task automatic cmp1(input string tag, input int act, input int exp, inout bit bad);
        if (act != exp) begin
            $display("FAIL %s vector %0d: actual %0h expected %0h", tag, vectors, act, exp);
            bad = 1;
        end
    endtask

    initial begin : monitor
        forever begin
            exp_t e;
            bit bad;
            wait (q.size() != 0);
            #1;
            e = q.pop_front();
            bad = 0;
            cmp1("R1 b_oe", b_oe, e.b_oe, bad);
            cmp1("R2 a_oe", a_oe, e.a_oe, bad);
            cmp1("R1/R8/R9 b_out", b_out, e.b_out, bad);
            cmp1("R2/R8/R9 a_out", a_out, e.a_out, bad);
            cmp1("R5/R6 b_par_out", b_par_out, e.b_par, bad);
            cmp1("R5/R6 a_par_out", a_par_out, e.a_par, bad);
            cmp1("R7/R10 err_a_n", err_a_n, e.err_a_n, bad);
            cmp1("R7/R10 err_b_n", err_b_n, e.err_b_n, bad);
            cmp1("R4 cfg_conflict", cfg_conflict, e.conflict, bad);
            vectors++;
            if (bad) fails++;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R9: reset cleared storage; closed latches present zero
        apply(6'b01_0_0_00, 8'hFF, 1'b1, 8'hA5, 1'b0);
        apply(6'b10_0_1_00, 8'h3C, 1'b0, 8'h77, 1'b1);
        // R8 then R9: open A, close it, change input, must hold
        apply(6'b01_0_0_10, 8'h81, 1'b1, 8'h00, 1'b0);
        apply(6'b01_0_0_00, 8'h12, 1'b0, 8'h00, 1'b0);
        // R10: B latch open sees generated parity
        apply(6'b01_0_1_11, 8'h07, 1'b1, 8'hF0, 1'b1);
        // R6 with parity error reflected back (R7)
        apply(6'b01_1_0_11, 8'h01, 1'b0, 8'h00, 1'b0);
        // R4 conflict
        apply(6'b00_0_0_11, 8'hC3, 1'b0, 8'h5A, 1'b1);
        // R3 idle
        apply(6'b11_1_1_11, 8'hAA, 1'b1, 8'h55, 1'b0);
        for (int rep = 0; rep < 6; rep++) begin
            for (int c = 0; c < 64; c++) begin
                apply(c[5:0], 8'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
            end
        end
        for (int k = 0; k < 200; k++) begin
            apply(6'($urandom), 8'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
        end
        @(negedge clk);
        #5;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule